// File: doc/BRIEF.md
# Shared-Hold-Latch Scan Tree Datapath

This block is the storage and launch datapath of a scan tree built for two-pattern delay testing. Each tree has one serial input that feeds several parallel segments of equal depth at once, so every flip-flop at a given level of a tree loads the same bit. A whole vector is therefore loaded in as many shift cycles as there are levels, however many segments the tree has. The leaf flip-flop of every segment is brought out for a response compactor.

Each level keeps only one hold latch, placed at one chosen segment. The flip-flops of the other segments reach the logic under test through a bypass multiplexer. That multiplexer passes either the level's latch or the flop's own value. A test sequence uses it as follows. The first vector is shifted in, with the latches opened on the last shift. The latches then close and hold that vector at the logic inputs while the second vector is shifted in behind them. Opening the latches then launches the transition, and one functional capture cycle records the response.

The scan input has no valid/ready handshake and no back-pressure. One bit is consumed from each tree's scan input on every clock edge where the test control is high. All controls are plain level signals sampled at the rising edge. The hold latches are the only exception: they are level-sensitive.

Top module: `shs_scan_forest`

## Requirements
- R1: While rst_n is low at a rising edge, every flip-flop clears; while rst_n is low, every hold latch clears. Right after reset, ppi and leaf_out are all zero.
- R2: On a rising edge with test_en=1, the level-0 flop of every segment of tree t loads scan_in[t], and the level-l flop (l>0) loads the level l-1 flop of the same segment. All segments of a tree therefore hold identical values at each level.
- R3: On a rising edge with test_en=0, each flop loads its own func_d bit. Bit (t*SEGS+s)*DEPTH+l belongs to tree t, segment s, level l, and ppi uses the same bit layout.
- R4: The hold latch of a level follows the level-l flop of segment HL_SEG while hold=1. It keeps its stored value while hold=0.
- R5: The ppi bit of segment HL_SEG always shows its level's latch. The ppi bit of any other segment shows the level's latch when hold=0 or force_sel=1, and its own flop when hold=1 and force_sel=0.
- R6: leaf_out[t*SEGS+s] equals the level DEPTH-1 flop of tree t, segment s.
- R7: After DEPTH shift cycles, the bit shifted first sits at level DEPTH-1 and the bit shifted last at level 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset for the flops; also clears the latches |
| scan_in | input | TREES | Serial test input, one per tree |
| test_en | input | 1 | 1: shift path into the flops; 0: functional capture |
| hold | input | 1 | 1: hold latches transparent; 0: latches keep their value |
| force_sel | input | 1 | 1: every bypass multiplexer selects the level latch |
| func_d | input | TREES*SEGS*DEPTH | Next-state bits from the combinational logic |
| ppi | output | TREES*SEGS*DEPTH | Values driven into the logic under test |
| leaf_out | output | TREES*SEGS | Leaf-level flop values for the response compactor |

## Verification
The bench runs a full two-pattern sequence: it loads the first vector with the latches opened on the last shift, then shifts a different second vector while the latches stay closed. A latch that leaked in that phase would show second-vector bits at ppi, and a broken fan-out would make segments of one tree disagree. Capture cycles use func_d patterns that differ between segments. A multiplexer that ignored force_sel, or picked the latch when it should pass its own flop, would then show the latch-bearing segment's bit on its neighbours. Level order is checked with asymmetric patterns, so a reversed shift direction lands the wrong bit at the leaf.

// File: rtl/shs_pkg.sv
package shs_pkg;
  // flat position of tree t, segment s, level l in ppi / func_d
  function automatic int cell_idx(input int t, input int s, input int l,
                                  input int segs, input int depth);
    return (t * segs + s) * depth + l;
  endfunction
endpackage

// File: rtl/shs_hold_latch.sv
module shs_hold_latch (
  input  logic rst_n,
  input  logic hold,
  input  logic d,
  output logic q
);
  always_latch begin
    if (!rst_n)    q <= 1'b0;
    else if (hold) q <= d;
  end
endmodule

// File: rtl/shs_cell.sv
module shs_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic test_en,
  input  logic shift_d,
  input  logic func_d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= 1'b0;
    else         q <= test_en ? shift_d : func_d;
  end

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |=> (q == $past(shift_d)));
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> (q == $past(func_d)));
endmodule

// File: rtl/shs_level.sv
module shs_level #(
  parameter int SEGS   = 3,
  parameter int HL_SEG = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_en,
  input  logic            hold,
  input  logic            force_sel,
  input  logic [SEGS-1:0] shift_in,
  input  logic [SEGS-1:0] func_d,
  output logic [SEGS-1:0] q,
  output logic [SEGS-1:0] ppi
);
  logic hl_q;
  logic use_latch;

  assign use_latch = !hold || force_sel;

  shs_hold_latch u_hl (
    .rst_n (rst_n),
    .hold  (hold),
    .d     (q[HL_SEG]),
    .q     (hl_q)
  );

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    shs_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .test_en (test_en),
      .shift_d (shift_in[s]),
      .func_d  (func_d[s]),
      .q       (q[s])
    );
    if (s == HL_SEG) begin : g_own
      assign ppi[s] = hl_q;
    end else begin : g_byp
      assign ppi[s] = use_latch ? hl_q : q[s];
      p_mux_flop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !force_sel) |-> (ppi[s] == q[s]));
    end
    p_mux_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold || force_sel) |-> (ppi[s] == ppi[HL_SEG]));
  end

  p_latch_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !$past(hold)) |-> $stable(hl_q));
  p_latch_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (ppi[HL_SEG] == q[HL_SEG]));
endmodule

// File: rtl/shs_scan_forest.sv
module shs_scan_forest #(
  parameter int DEPTH  = 4,
  parameter int SEGS   = 3,
  parameter int TREES  = 2,
  parameter int HL_SEG = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TREES-1:0]            scan_in,
  input  logic                        test_en,
  input  logic                        hold,
  input  logic                        force_sel,
  input  logic [TREES*SEGS*DEPTH-1:0] func_d,
  output logic [TREES*SEGS*DEPTH-1:0] ppi,
  output logic [TREES*SEGS-1:0]       leaf_out
);
  localparam int NCELL = TREES * SEGS * DEPTH;

  logic [NCELL-1:0] q_all;

  for (genvar t = 0; t < TREES; t++) begin : g_tree
    for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
      logic [SEGS-1:0] sh_in, fd, lq, lp;
      for (genvar s = 0; s < SEGS; s++) begin : g_map
        localparam int IDX = shs_pkg::cell_idx(t, s, l, SEGS, DEPTH);
        if (l == 0) begin : g_root
          assign sh_in[s] = scan_in[t];
        end else begin : g_chain
          assign sh_in[s] = q_all[shs_pkg::cell_idx(t, s, l - 1, SEGS, DEPTH)];
        end
        assign fd[s]      = func_d[IDX];
        assign q_all[IDX] = lq[s];
        assign ppi[IDX]   = lp[s];
      end
      shs_level #(.SEGS(SEGS), .HL_SEG(HL_SEG)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (test_en),
        .hold      (hold),
        .force_sel (force_sel),
        .shift_in  (sh_in),
        .func_d    (fd),
        .q         (lq),
        .ppi       (lp)
      );
      if (l == 0) begin : g_fan_chk
        p_tree_fan_r2: assert property (@(posedge clk) disable iff (!rst_n)
          test_en |=> (lq == {SEGS{$past(scan_in[t])}}));
      end
    end
    for (genvar s = 0; s < SEGS; s++) begin : g_leaf
      assign leaf_out[t*SEGS+s] = q_all[shs_pkg::cell_idx(t, s, DEPTH - 1, SEGS, DEPTH)];
    end
  end
endmodule

// File: tb/shs_scan_forest_bench.sv
module shs_scan_forest_bench;
  localparam int D  = 4;
  localparam int S  = 3;
  localparam int T  = 2;
  localparam int HL = 0;
  localparam int N  = T * S * D;
  localparam int L  = T * S;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [T-1:0] scan_in = '0;
  logic         test_en = 1'b0, hold = 1'b0, force_sel = 1'b0;
  logic [N-1:0] func_d = '0;
  logic [N-1:0] ppi;
  logic [L-1:0] leaf_out;

  always #10 clk = ~clk;

  shs_scan_forest #(.DEPTH(D), .SEGS(S), .TREES(T), .HL_SEG(HL)) u_shs_scan_forest (
    .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .test_en(test_en),
    .hold(hold), .force_sel(force_sel), .func_d(func_d),
    .ppi(ppi), .leaf_out(leaf_out)
  );

  logic [N-1:0]   mf = '0;
  logic [T*D-1:0] ml = '0;
  logic [N+L-1:0] exp_q[$];
  string          tag_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic int ix(int t, int s, int l);
    return (t * S + s) * D + l;
  endfunction

  task automatic step(input logic [T-1:0] sin, input logic te, input logic hd,
                      input logic fs, input logic [N-1:0] fd, input string tag);
    logic [N-1:0] nf;
    logic [N-1:0] ep;
    logic [L-1:0] el;
    @(negedge clk);
    scan_in = sin; test_en = te; hold = hd; force_sel = fs; func_d = fd;
    for (int t = 0; t < T; t++)
      for (int s = 0; s < S; s++)
        for (int l = 0; l < D; l++)
          nf[ix(t,s,l)] = te ? ((l == 0) ? sin[t] : mf[ix(t,s,l-1)]) : fd[ix(t,s,l)];
    mf = nf;
    for (int t = 0; t < T; t++)
      for (int l = 0; l < D; l++)
        if (hd) ml[t*D+l] = mf[ix(t,HL,l)];
    for (int t = 0; t < T; t++)
      for (int s = 0; s < S; s++) begin
        for (int l = 0; l < D; l++)
          ep[ix(t,s,l)] = (s == HL || !hd || fs) ? ml[t*D+l] : mf[ix(t,s,l)];
        el[t*S+s] = mf[ix(t,s,D-1)];
      end
    exp_q.push_back({ep, el});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [N+L-1:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if ({ppi, leaf_out} !== e) begin
        fails++;
        $display("FAIL %s: ppi/leaf actual %h expected %h", tg, {ppi, leaf_out}, e);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  logic [D-1:0] v1 [T];
  logic [D-1:0] v2 [T];

  initial begin
    v1[0] = 4'b1101; v1[1] = 4'b0110;
    v2[0] = 4'b0011; v2[1] = 4'b1010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step('0, 1'b0, 1'b0, 1'b0, '0, "R1 reset state");
    // load V1, open latches on the last shift (R2, R7)
    for (int k = 0; k < D; k++) begin
      logic [T-1:0] sb;
      for (int t = 0; t < T; t++) sb[t] = v1[t][D-1-k];
      step(sb, 1'b1, (k == D-1), 1'b0, '0, (k == D-1) ? "R7 full vector" : "R2 shift");
    end
    // shift V2 behind closed latches (R4, R6)
    for (int k = 0; k < D; k++) begin
      logic [T-1:0] sb;
      for (int t = 0; t < T; t++) sb[t] = v2[t][D-1-k];
      step(sb, 1'b1, 1'b0, 1'b0, '0, "R4 latch keeps V1 / R6 leaf");
    end
    step('0, 1'b1, 1'b1, 1'b0, '0, "R5 own flop path");
    step('0, 1'b0, 1'b0, 1'b0, 24'hA5C39E, "R3 capture behind closed latch");
    step('0, 1'b0, 1'b1, 1'b1, 24'h3C5A96, "R5 force selects latch");
    step('0, 1'b0, 1'b1, 1'b0, 24'h9617E4, "R3 capture seen at ppi");
    step('0, 1'b0, 1'b1, 1'b0, 24'h5E0F3B, "R5 bypass own flop");
    step(2'b10, 1'b1, 1'b0, 1'b1, '0, "R4 latch closed after capture");
    step(2'b01, 1'b1, 1'b0, 1'b0, '0, "R2 shift after capture");
    step(2'b11, 1'b1, 1'b1, 1'b1, '0, "R5 force with open latch");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule